// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the address for each beat of a four-word burst on a synchronous memory port. A cycle with the start strobe low captures a full base address. Each following cycle with the strobe high moves to the next beat. Only the two least-significant address bits change from beat to beat. The upper bits keep the value captured with the base.

Two beat orders are available. A static order input chooses between them, and its value is captured together with the base address. In linear order the low bits count upward from the base and wrap modulo four. In interleaved order the low bits are the base low bits XOR a beat counter that runs 0, 1, 2, 3. A burst never leaves its aligned four-word block. A stall input or a deselect input freezes the whole sequencer for as long as either one is high.

The block is a small piece of control logic and carries no data stream, so every pin is a plain level signal with no handshake. The address is formed combinationally from registers. A capture or an advance is therefore visible on `burst_addr` directly after the clock edge that performs it.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst_n` is low, and directly after reset, `burst_addr` is all zeros, `beat` is 0, and the captured order is linear.
- R2: On a rising edge with `stall`=0, `desel`=0 and `load_n`=0, the block captures `base_addr` and the order input. Right after that edge, `burst_addr` equals the captured base and `beat` is 0.
- R3: On a rising edge with `stall`=0, `desel`=0 and `load_n`=1, `beat` increases by one modulo 4.
- R4: When the captured order is linear (`ilv_mode`=0 at capture), `burst_addr[1:0]` equals (base low bits + `beat`) mod 4. For example, base low bits 1 give 1, 2, 3, 0.
- R5: When the captured order is interleaved (`ilv_mode`=1 at capture), `burst_addr[1:0]` equals base low bits XOR `beat`. For example, base low bits 1 give 1, 0, 3, 2.
- R6: `burst_addr[AW-1:2]` always equals the upper bits of the captured base. A wrap of the low bits never carries into the upper bits, and this holds on every advance.
- R7: While `stall` is 1, `burst_addr` and `beat` keep their values, whatever `load_n`, `ilv_mode` or `base_addr` do.
- R8: While `desel` is 1, `burst_addr` and `beat` keep their values, whatever `load_n`, `ilv_mode` or `base_addr` do.
- R9: A change of `ilv_mode` between captures has no effect on the running burst. The new order applies only from the next capture.
- R10: After four advances from a capture, `burst_addr` returns to the captured base. Further advances repeat the same four-address cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stall | input | 1 | High: hold all state (clock suspend) |
| desel | input | 1 | High: hold all state (port deselected) |
| load_n | input | 1 | Low: capture base; high: advance one beat |
| ilv_mode | input | 1 | Order select sampled at capture: 0 linear, 1 interleaved |
| base_addr | input | AW | Base address captured when `load_n` is low |
| burst_addr | output | AW | Address of the current beat |
| beat | output | 2 | Beat index since the last capture, 0 to 3 |

## Verification
Each result is due in the first cycle after the edge that produced it, because the outputs are decoded from state updated on that edge. The bench changes inputs on the falling edge, waits for one rising edge, and samples one time unit later. A capture, an advance or a hold is therefore checked against the state left by exactly one edge. Reset is checked the same way: it is sampled after the first edge with `rst_n` low.

// File: rtl/burst_addr_seq_pkg.sv
package burst_addr_seq_pkg;

  // Order of the low address bits within one aligned block
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;

endpackage

// File: rtl/bseq_base_reg.sv
module bseq_base_reg
  import burst_addr_seq_pkg::*;
#(
  parameter int AW    = 20,
  parameter int LOW_W = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_en,
  input  logic [AW-1:0]       base_in,
  input  order_e              mode_in,
  output logic [AW-LOW_W-1:0] upper_q,
  output logic [LOW_W-1:0]    low_q,
  output order_e              mode_q
);

  localparam int UP_W = AW - LOW_W;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      upper_q <= '0;
      low_q   <= '0;
      mode_q  <= ORD_LINEAR;
    end else if (load_en) begin
      upper_q <= base_in[AW-1 -: UP_W];
      low_q   <= base_in[LOW_W-1:0];
      mode_q  <= mode_in;
    end
  end

endmodule

// File: rtl/bseq_beat_ctr.sv
module bseq_beat_ctr #(
  parameter int LOW_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [LOW_W-1:0] beat_q
);

  // Natural modulo-2^LOW_W rollover gives the wrap
  always_ff @(posedge clk) begin
    if (!rst_n)   beat_q <= '0;
    else if (clr) beat_q <= '0;
    else if (inc) beat_q <= beat_q + LOW_W'(1);
  end

endmodule

// File: rtl/bseq_order.sv
module bseq_order
  import burst_addr_seq_pkg::*;
#(
  parameter int LOW_W = 2
) (
  input  logic [LOW_W-1:0] base_low,
  input  logic [LOW_W-1:0] beat,
  input  order_e           mode,
  output logic [LOW_W-1:0] low_out
);

  logic [LOW_W-1:0] lin_low;
  logic [LOW_W-1:0] ilv_low;

  // Linear: add without carry-out, so the block boundary is never crossed
  assign lin_low = base_low + beat;

  // Interleaved: per-bit flip by the beat index
  for (genvar i = 0; i < LOW_W; i++) begin : g_ilv
    assign ilv_low[i] = base_low[i] ^ beat[i];
  end

  always_comb begin
    unique case (mode)
      ORD_INTERLEAVE: low_out = ilv_low;
      default:        low_out = lin_low;
    endcase
  end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_addr_seq_pkg::*;
#(
  parameter int AW        = 20,
  parameter int BURST_LEN = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         stall,
  input  logic                         desel,
  input  logic                         load_n,
  input  logic                         ilv_mode,
  input  logic [AW-1:0]                base_addr,
  output logic [AW-1:0]                burst_addr,
  output logic [$clog2(BURST_LEN)-1:0] beat
);

  localparam int LOW_W = $clog2(BURST_LEN);
  localparam int UP_W  = AW - LOW_W;

  logic             run_en;
  logic             cap_en;
  logic             step_en;
  logic [UP_W-1:0]  upper_q;
  logic [LOW_W-1:0] low_q;
  order_e           mode_q;
  logic [LOW_W-1:0] beat_q;
  logic [LOW_W-1:0] low_now;

  // Either freeze source blocks both capture and advance
  assign run_en  = !stall && !desel;
  assign cap_en  = run_en && !load_n;
  assign step_en = run_en && load_n;

  bseq_base_reg #(.AW(AW), .LOW_W(LOW_W)) u_base (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_en (cap_en),
    .base_in (base_addr),
    .mode_in (order_e'(ilv_mode)),
    .upper_q (upper_q),
    .low_q   (low_q),
    .mode_q  (mode_q)
  );

  bseq_beat_ctr #(.LOW_W(LOW_W)) u_beat (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (cap_en),
    .inc    (step_en),
    .beat_q (beat_q)
  );

  bseq_order #(.LOW_W(LOW_W)) u_order (
    .base_low (low_q),
    .beat     (beat_q),
    .mode     (mode_q),
    .low_out  (low_now)
  );

  assign burst_addr = {upper_q, low_now};
  assign beat       = beat_q;

endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int AW    = 20,
  parameter int LOW_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stall,
  input logic             desel,
  input logic             load_n,
  input logic             ilv_mode,
  input logic [AW-1:0]    base_addr,
  input logic [AW-1:0]    burst_addr,
  input logic [LOW_W-1:0] beat
);

  logic             run;
  logic             sh_ilv;
  logic [LOW_W-1:0] sh_low;

  assign run = !stall && !desel;

  // Shadow of the order and base low bits seen at each capture
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_ilv <= 1'b0;
      sh_low <= '0;
    end else if (run && !load_n) begin
      sh_ilv <= ilv_mode;
      sh_low <= base_addr[LOW_W-1:0];
    end
  end

  a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load_n) |=> (burst_addr == $past(base_addr)) && (beat == '0));

  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run && load_n) |=> (beat == LOW_W'($past(beat) + LOW_W'(1))));

  a_r6_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (run && load_n) |=> $stable(burst_addr[AW-1:LOW_W]));

  a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> ($stable(burst_addr) && $stable(beat)));

  a_r8_desel_hold: assert property (@(posedge clk) disable iff (!rst_n)
    desel |=> ($stable(burst_addr) && $stable(beat)));

  // R4 and R5: low bits follow the order captured at the last capture (R9)
  a_r5_order: assert property (@(posedge clk) disable iff (!rst_n)
    burst_addr[LOW_W-1:0] ==
      (sh_ilv ? (sh_low ^ beat) : LOW_W'(sh_low + beat)));

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.AW(AW), .LOW_W(LOW_W)) u_chk (.*);

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb_top;

  localparam int AW = 20;
  localparam int NV = 22;

  typedef struct packed {
    logic          stall;
    logic          desel;
    logic          load_n;
    logic          mode;
    logic [AW-1:0] base;
    logic [AW-1:0] exp_addr;
    logic [1:0]    exp_beat;
    logic [7:0]    req;
  } vec_t;

  // stall desel load_n mode base exp_addr exp_beat requirement
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b0,1'b0,1'b0,20'h12341,20'h12341,2'd0,8'd2},  // R2 linear capture
    '{1'b0,1'b0,1'b1,1'b0,20'h00000,20'h12342,2'd1,8'd4},  // R4
    '{1'b0,1'b0,1'b1,1'b0,20'h00000,20'h12343,2'd2,8'd3},  // R3
    '{1'b0,1'b0,1'b1,1'b0,20'h00000,20'h12340,2'd3,8'd6},  // R6 no carry
    '{1'b0,1'b0,1'b1,1'b0,20'h00000,20'h12341,2'd0,8'd10}, // R10 back at base
    '{1'b0,1'b0,1'b1,1'b1,20'h00000,20'h12342,2'd1,8'd9},  // R9 mode flip ignored
    '{1'b1,1'b0,1'b1,1'b0,20'h00000,20'h12342,2'd1,8'd7},  // R7 stall advance
    '{1'b1,1'b0,1'b0,1'b1,20'h55555,20'h12342,2'd1,8'd7},  // R7 stall capture
    '{1'b0,1'b1,1'b1,1'b0,20'h00000,20'h12342,2'd1,8'd8},  // R8 desel advance
    '{1'b0,1'b1,1'b0,1'b1,20'h55555,20'h12342,2'd1,8'd8},  // R8 desel capture
    '{1'b0,1'b0,1'b1,1'b0,20'h00000,20'h12343,2'd2,8'd4},  // R4 resumes
    '{1'b0,1'b0,1'b0,1'b1,20'hABCD1,20'hABCD1,2'd0,8'd2},  // R2 interleaved capture
    '{1'b0,1'b0,1'b1,1'b0,20'h00000,20'hABCD0,2'd1,8'd9},  // R9 still interleaved
    '{1'b0,1'b0,1'b1,1'b0,20'h00000,20'hABCD3,2'd2,8'd5},  // R5
    '{1'b0,1'b0,1'b1,1'b0,20'h00000,20'hABCD2,2'd3,8'd5},  // R5
    '{1'b0,1'b0,1'b1,1'b0,20'h00000,20'hABCD1,2'd0,8'd10}, // R10 wrap
    '{1'b0,1'b0,1'b0,1'b1,20'h00002,20'h00002,2'd0,8'd2},  // R2
    '{1'b0,1'b0,1'b1,1'b1,20'h00000,20'h00003,2'd1,8'd5},  // R5 base 2
    '{1'b0,1'b0,1'b1,1'b1,20'h00000,20'h00000,2'd2,8'd5},  // R5
    '{1'b0,1'b0,1'b1,1'b1,20'h00000,20'h00001,2'd3,8'd5},  // R5
    '{1'b0,1'b0,1'b0,1'b0,20'hFFFFF,20'hFFFFF,2'd0,8'd2},  // R2 top of space
    '{1'b0,1'b0,1'b1,1'b0,20'h00000,20'hFFFFC,2'd1,8'd6}   // R6 no carry out
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          stall, desel, load_n, ilv_mode;
  logic [AW-1:0] base_addr;
  logic [AW-1:0] burst_addr;
  logic [1:0]    beat;

  int n_checks = 0;
  int n_errors = 0;
  int cycles   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  burst_addr_seq #(.AW(AW), .BURST_LEN(4)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .stall      (stall),
    .desel      (desel),
    .load_n     (load_n),
    .ilv_mode   (ilv_mode),
    .base_addr  (base_addr),
    .burst_addr (burst_addr),
    .beat       (beat)
  );

  task automatic check(input int req, input logic [AW-1:0] ea, input logic [1:0] eb);
    n_checks++;
    if (burst_addr !== ea || beat !== eb) begin
      n_errors++;
      $display("FAIL R%0d: addr=%h beat=%0d expected addr=%h beat=%0d",
               req, burst_addr, beat, ea, eb);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      n_errors++;
      $display("FAIL watchdog: cycles=%0d expected below 5000", cycles);
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; stall = 1'b0; desel = 1'b0; load_n = 1'b1;
    ilv_mode = 1'b0; base_addr = '0;
    repeat (2) @(posedge clk);
    #1 check(1, '0, 2'd0);                 // R1 reset state
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      stall = VEC[i].stall; desel = VEC[i].desel; load_n = VEC[i].load_n;
      ilv_mode = VEC[i].mode; base_addr = VEC[i].base;
      @(posedge clk);
      #1 check(int'(VEC[i].req), VEC[i].exp_addr, VEC[i].exp_beat);
    end

    // R6: long run of advances stays inside the block of 0xFFFFC
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      stall = 1'b0; desel = 1'b0; load_n = 1'b1;
      @(posedge clk);
      #1 check(6, {18'h3FFFF, 2'(3 + 2 + k)}, 2'(2 + k));
    end

    // R1: reset in mid-burst clears state; a following step runs linear from 0
    @(negedge clk);
    rst_n = 1'b0; ilv_mode = 1'b1;
    @(posedge clk);
    #1 check(1, '0, 2'd0);
    @(negedge clk);
    rst_n = 1'b1; load_n = 1'b1;
    @(posedge clk);
    #1 check(1, 20'h00001, 2'd1);

    @(negedge clk);
    finish_run();
  end

endmodule